// File: doc/BRIEF.md
# Half-Rate to Full-Rate Write Bridge

This block carries write transactions from a processor on a slow clock to a peripheral on a fast clock. The fast clock runs at exactly twice the slow frequency, and both come from one PLL, so the two never drift apart. They are not edge-aligned, though: the slow edge may lag the fast edge by a few nanoseconds. No asynchronous synchronizer is used. Every slow-side field is registered on the slow rising edge. The fast falling edge then recaptures it straight from that register, with no logic in between. The fast-domain outputs behave like any other fast-domain register outputs.

A slow period spans two fast cycles, so the peripheral sees every captured field at two fast rising edges. Address, data and byte enables are held for both. The write strobe and the side-effect strobes are masked so that they are high for only the first of the two. Each slow-side write therefore takes effect exactly once.

The block finds the first half of each slow period without any extra control signal. A toggle bit flips on every slow edge and travels through both stages. A change in this bit at a fast falling edge marks the first half. After reset, tracking therefore realigns by itself at the first slow edge. `rst_n` is an active-low asynchronous reset for both stages. It is expected to be released away from both clock edges.

Top module: `hb_bridge`

## Requirements
- R1: While `rst_n` is low, `f_wr` and `f_fx` are 0, and `f_addr`, `f_wdata` and `f_be` read 0, whatever the slow-side inputs do.
- R2: Take a write captured at a slow rising edge that lags fast rising edge T by less than half a fast period. The peripheral sees `f_wr` high at the fast rising edge one fast period after T.
- R3: At that edge, `f_addr`, `f_wdata` and `f_be` equal the values `s_addr`, `s_wdata` and `s_be` held at the capturing slow edge.
- R4: `f_addr`, `f_wdata` and `f_be` do not change between the strobed fast rising edge and the next fast rising edge.
- R5: `f_wr` is high at exactly one of the two fast rising edges of each slow period in which a write was captured, and low at the other.
- R6: Writes on consecutive slow cycles each give exactly one `f_wr` pulse, in issue order, with consecutive pulses exactly two fast cycles apart.
- R7: Each bit of `f_fx` follows the matching bit of `s_fx` under the same one-fast-cycle masking, independently of `s_wr`.
- R8: Slow cycles with `s_wr` and `s_fx` low produce no strobe at the fast side, even while address and data change.
- R9: R2 to R6 hold for slow-edge lags of 0 up to just under half a fast period.
- R10: After reset is released, the first slow rising edge realigns the phase tracking. A write captured at that edge gives exactly one `f_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Half-rate clock, same PLL as clk_fast |
| clk_fast | input | 1 | Full-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset, both stages |
| s_addr | input | ADDR_W | Write address from the slow side |
| s_wdata | input | DATA_W | Write data from the slow side |
| s_be | input | BE_W | Byte enables, level signals, not masked |
| s_wr | input | 1 | Write request for this slow cycle |
| s_fx | input | FX_W | Side-effect strobes for this slow cycle |
| f_addr | output | ADDR_W | Address to the fast peripheral |
| f_wdata | output | DATA_W | Data to the fast peripheral |
| f_be | output | BE_W | Byte enables to the fast peripheral |
| f_wr | output | 1 | Write strobe, one fast cycle per write |
| f_fx | output | FX_W | Side-effect strobes, one fast cycle each |

## Verification
A single isolated write with side-effect bits shows whether the strobe lands on the right fast edge and is dropped on the second. It also shows whether the payload is held across both fast edges. Back-to-back writes with distinct addresses expose doubled, lost or reordered strobes and a wrong pulse spacing. Idle cycles with changing address and data, and side-effect strobes without a write, separate the masking of each strobe bit from the write path. These patterns are repeated at three slow-edge lags. A reset raised with a write pending, then released, shows the quiet reset state and the realignment of the phase tracking.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Fast-domain phase tracking state, all updated on the fast falling edge.
    typedef struct packed {
        logic prev_tog;      // toggle value seen at the previous falling edge
        logic locked;        // at least one slow edge has been observed
        logic expect_first;  // predicted value of first-half at the next edge
    } phase_state_t;

    // A slow edge happened between two falling edges when the toggle differs.
    function automatic logic slow_edge_seen(input logic now_tog, input logic old_tog);
        return now_tog ^ old_tog;
    endfunction

endpackage

// File: rtl/hb_launch.sv
module hb_launch #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int FX_W   = 2
) (
    input  logic              clk_slow,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [BE_W-1:0]   s_be,
    input  logic              s_wr,
    input  logic [FX_W-1:0]   s_fx,
    output logic [ADDR_W-1:0] l_addr,
    output logic [DATA_W-1:0] l_wdata,
    output logic [BE_W-1:0]   l_be,
    output logic              l_wr,
    output logic [FX_W-1:0]   l_fx,
    output logic              l_tog
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic              wr;
        logic [FX_W-1:0]   fx;
        logic              tog;
    } launch_t;

    launch_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.addr  = s_addr;
        st_d.wdata = s_wdata;
        st_d.be    = s_be;
        st_d.wr    = s_wr;
        st_d.fx    = s_fx;
        st_d.tog   = ~st_q.tog;
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign l_addr  = st_q.addr;
    assign l_wdata = st_q.wdata;
    assign l_be    = st_q.be;
    assign l_wr    = st_q.wr;
    assign l_fx    = st_q.fx;
    assign l_tog   = st_q.tog;

endmodule

// File: rtl/hb_capture.sv
module hb_capture #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int FX_W   = 2
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [BE_W-1:0]   l_be,
    input  logic              l_wr,
    input  logic [FX_W-1:0]   l_fx,
    input  logic              l_tog,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_wdata,
    output logic [BE_W-1:0]   c_be,
    output logic              c_wr,
    output logic [FX_W-1:0]   c_fx,
    output logic              c_tog
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic              wr;
        logic [FX_W-1:0]   fx;
        logic              tog;
    } capture_t;

    capture_t st_d, st_q;

    // Plain wires from the slow-edge registers: no gate sits on this path.
    always_comb begin
        st_d       = st_q;
        st_d.addr  = l_addr;
        st_d.wdata = l_wdata;
        st_d.be    = l_be;
        st_d.wr    = l_wr;
        st_d.fx    = l_fx;
        st_d.tog   = l_tog;
    end

    always_ff @(negedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c_addr  = st_q.addr;
    assign c_wdata = st_q.wdata;
    assign c_be    = st_q.be;
    assign c_wr    = st_q.wr;
    assign c_fx    = st_q.fx;
    assign c_tog   = st_q.tog;

endmodule

// File: rtl/hb_phase.sv
module hb_phase
    import hb_pkg::*;
(
    input  logic clk_fast,
    input  logic rst_n,
    input  logic c_tog,
    output logic first_half
);

    phase_state_t st_d, st_q;
    logic         edge_now;

    always_comb begin
        edge_now          = slow_edge_seen(c_tog, st_q.prev_tog);
        st_d              = st_q;
        st_d.prev_tog     = c_tog;
        st_d.locked       = st_q.locked | edge_now;
        st_d.expect_first = ~edge_now;
    end

    always_ff @(negedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_half = edge_now;

    // Once locked, first halves must alternate with second halves (fixed 2:1).
    assert_phase_alternates_R6: assert property (
        @(negedge clk_fast) disable iff (!rst_n)
        st_q.locked |-> (first_half == st_q.expect_first)
    );

endmodule

// File: rtl/hb_gate.sv
module hb_gate #(
    parameter int FX_W = 2
) (
    input  logic            c_wr,
    input  logic [FX_W-1:0] c_fx,
    input  logic            first_half,
    output logic            f_wr,
    output logic [FX_W-1:0] f_fx
);

    assign f_wr = c_wr & first_half;

    for (genvar gi = 0; gi < FX_W; gi++) begin : g_fx_mask
        assign f_fx[gi] = c_fx[gi] & first_half;
    end

endmodule

// File: rtl/hb_bridge.sv
module hb_bridge #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int FX_W   = 2
) (
    input  logic              clk_slow,
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [BE_W-1:0]   s_be,
    input  logic              s_wr,
    input  logic [FX_W-1:0]   s_fx,
    output logic [ADDR_W-1:0] f_addr,
    output logic [DATA_W-1:0] f_wdata,
    output logic [BE_W-1:0]   f_be,
    output logic              f_wr,
    output logic [FX_W-1:0]   f_fx
);

    logic [ADDR_W-1:0] l_addr;
    logic [DATA_W-1:0] l_wdata;
    logic [BE_W-1:0]   l_be;
    logic              l_wr;
    logic [FX_W-1:0]   l_fx;
    logic              l_tog;
    logic              c_wr;
    logic [FX_W-1:0]   c_fx;
    logic              c_tog;
    logic              first_half;

    hb_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .FX_W(FX_W)) i_launch (
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .s_addr   (s_addr),
        .s_wdata  (s_wdata),
        .s_be     (s_be),
        .s_wr     (s_wr),
        .s_fx     (s_fx),
        .l_addr   (l_addr),
        .l_wdata  (l_wdata),
        .l_be     (l_be),
        .l_wr     (l_wr),
        .l_fx     (l_fx),
        .l_tog    (l_tog)
    );

    hb_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .FX_W(FX_W)) i_capture (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .l_addr   (l_addr),
        .l_wdata  (l_wdata),
        .l_be     (l_be),
        .l_wr     (l_wr),
        .l_fx     (l_fx),
        .l_tog    (l_tog),
        .c_addr   (f_addr),
        .c_wdata  (f_wdata),
        .c_be     (f_be),
        .c_wr     (c_wr),
        .c_fx     (c_fx),
        .c_tog    (c_tog)
    );

    hb_phase i_phase (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .c_tog      (c_tog),
        .first_half (first_half)
    );

    hb_gate #(.FX_W(FX_W)) i_gate (
        .c_wr       (c_wr),
        .c_fx       (c_fx),
        .first_half (first_half),
        .f_wr       (f_wr),
        .f_fx       (f_fx)
    );

    // Reset keeps every fast-side output quiet.
    always @(posedge clk_fast) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (f_wr == 1'b0 && f_fx == '0 && f_addr == '0);
        end
    end

    // Payload is held across the second fast edge of the slow period.
    assert_hold_fields_R4: assert property (
        @(posedge clk_fast) disable iff (!rst_n)
        f_wr |=> ($stable(f_addr) && $stable(f_wdata) && $stable(f_be))
    );

    // A write strobe never stays high for two fast rising edges.
    assert_single_pulse_R5: assert property (
        @(posedge clk_fast) disable iff (!rst_n)
        f_wr |=> !f_wr
    );

    // Side-effect strobes are masked the same way.
    assert_fx_single_R7: assert property (
        @(posedge clk_fast) disable iff (!rst_n)
        (|f_fx) |=> (f_fx == '0)
    );

endmodule

// File: tb/test_hb_bridge.sv
`timescale 1ns/100ps
module test_hb_bridge;

    localparam int      AW    = 8;
    localparam int      DW    = 16;
    localparam int      BW    = 2;
    localparam int      FW    = 2;
    localparam realtime TFAST = 8.0;
    localparam int      LOGN  = 256;

    logic          clk_fast = 1'b0;
    logic          clk_slow = 1'b0;
    logic          rst_n;
    realtime       skew_ns  = 0.0;
    logic [AW-1:0] s_addr   = '0;
    logic [DW-1:0] s_wdata  = '0;
    logic [BW-1:0] s_be     = '0;
    logic          s_wr     = 1'b0;
    logic [FW-1:0] s_fx     = '0;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] f_wdata;
    logic [BW-1:0] f_be;
    logic          f_wr;
    logic [FW-1:0] f_fx;

    int n_cmp = 0;
    int n_bad = 0;

    hb_bridge #(.ADDR_W(AW), .DATA_W(DW), .BE_W(BW), .FX_W(FW)) i_hb_bridge (
        .clk_slow (clk_slow), .clk_fast (clk_fast), .rst_n (rst_n),
        .s_addr (s_addr), .s_wdata (s_wdata), .s_be (s_be), .s_wr (s_wr), .s_fx (s_fx),
        .f_addr (f_addr), .f_wdata (f_wdata), .f_be (f_be), .f_wr (f_wr), .f_fx (f_fx)
    );

    // 125 MHz fast clock; slow clock toggles on every fast rising edge after a lag.
    always #(TFAST/2) clk_fast = ~clk_fast;
    always @(posedge clk_fast) begin
        #(skew_ns);
        clk_slow = ~clk_slow;
    end

    // Peripheral model: logs every write strobe seen at a fast rising edge.
    int            fcyc  = 0;
    int            got_n = 0;
    int            fx_n  = 0;
    logic [AW-1:0] got_a [LOGN];
    logic [DW-1:0] got_d [LOGN];
    int            got_c [LOGN];

    always @(posedge clk_fast) begin
        fcyc = fcyc + 1;
        if (f_wr === 1'b1) begin
            if (got_n < LOGN) begin
                got_a[got_n] = f_addr;
                got_d[got_n] = f_wdata;
                got_c[got_n] = fcyc;
            end
            got_n = got_n + 1;
        end
        fx_n = fx_n + $countones(f_fx);
    end

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // R1: outputs quiet during the power-on reset.
    task automatic t_reset_state();
        repeat (3) @(posedge clk_fast);
        #1;
        check_eq("R1", "f_wr in reset", f_wr, 0);
        check_eq("R1", "f_fx in reset", f_fx, 0);
        check_eq("R1", "f_addr in reset", f_addr, 0);
        check_eq("R1", "f_wdata in reset", f_wdata, 0);
    endtask

    // R2 R3 R4 R5 R7 R9: one isolated write with a side-effect bit.
    task automatic t_single(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk_slow);
        s_addr = a; s_wdata = d; s_be = 2'b10; s_wr = 1'b1; s_fx = 2'b01;
        @(posedge clk_slow);
        @(posedge clk_fast);
        #1;
        check_eq("R2", "f_wr first edge", f_wr, 1);
        check_eq("R3", "f_addr", f_addr, a);
        check_eq("R3", "f_wdata", f_wdata, d);
        check_eq("R7", "f_fx first edge", f_fx, 2'b01);
        s_wr = 1'b0; s_fx = '0; s_addr = ~a; s_wdata = ~d; s_be = 2'b01;
        @(posedge clk_fast);
        #1;
        check_eq("R5", "f_wr second edge", f_wr, 0);
        check_eq("R7", "f_fx second edge", f_fx, 0);
        check_eq("R4", "f_addr held", f_addr, a);
        check_eq("R4", "f_be held", f_be, 2'b10);
        check_eq("R9", "f_wdata held at lag", f_wdata, d);
    endtask

    // R6 R3 R9: consecutive writes, each seen once, in order, two fast cycles apart.
    task automatic t_burst(input int n, input logic [AW-1:0] base);
        int start;
        start = got_n;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_slow);
            s_addr = base + AW'(i); s_wdata = DW'(16'h5A00 + i * 3); s_wr = 1'b1;
        end
        @(negedge clk_slow);
        s_wr = 1'b0;
        repeat (4) @(posedge clk_slow);
        #1;
        check_eq("R6", "burst strobe count", got_n - start, n);
        for (int i = 0; i < n; i++) begin
            check_eq("R6", "burst addr order", got_a[start + i], base + AW'(i));
            check_eq("R3", "burst data", got_d[start + i], DW'(16'h5A00 + i * 3));
            if (i > 0) check_eq("R6", "strobe spacing", got_c[start + i] - got_c[start + i - 1], 2);
        end
        check_eq("R9", "burst at lag complete", got_n - start, n);
    endtask

    // R8: idle slow cycles with moving address and data give no strobe.
    task automatic t_idle();
        int w0;
        int x0;
        w0 = got_n; x0 = fx_n;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_slow);
            s_addr = AW'(8'hC0 + i); s_wdata = DW'(i * 257); s_wr = 1'b0; s_fx = '0;
        end
        repeat (3) @(posedge clk_slow);
        #1;
        check_eq("R8", "no write strobes when idle", got_n - w0, 0);
        check_eq("R8", "no fx strobes when idle", fx_n - x0, 0);
    endtask

    // R7: side-effect strobes without a write, both bits once each.
    task automatic t_fx_only();
        int w0;
        int x0;
        w0 = got_n; x0 = fx_n;
        @(negedge clk_slow);
        s_fx = 2'b11;
        @(negedge clk_slow);
        s_fx = 2'b00;
        repeat (3) @(posedge clk_slow);
        #1;
        check_eq("R7", "fx pulses per bit", fx_n - x0, 2);
        check_eq("R7", "fx without write", got_n - w0, 0);
    endtask

    // R1 R10: reset with a write pending, then realignment after release.
    task automatic t_reset_mid();
        int w0;
        @(negedge clk_fast);
        #1;
        rst_n = 1'b0;
        s_addr = 8'h3C; s_wdata = 16'hBEEF; s_wr = 1'b1;
        #1;
        check_eq("R1", "f_addr cleared by reset", f_addr, 0);
        check_eq("R1", "f_wr low in reset", f_wr, 0);
        w0 = got_n;
        repeat (3) @(posedge clk_slow);
        #1;
        check_eq("R1", "no strobe while reset", got_n - w0, 0);
        @(negedge clk_fast);
        #1;
        rst_n = 1'b1;
        @(posedge clk_slow);
        #1;
        s_wr = 1'b0;
        repeat (4) @(posedge clk_slow);
        #1;
        check_eq("R10", "one strobe after release", got_n - w0, 1);
        check_eq("R10", "addr after release", got_a[w0], 8'h3C);
        check_eq("R10", "data after release", got_d[w0], 16'hBEEF);
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset_state();
        @(negedge clk_fast);
        #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk_slow);
        skew_ns = 0.0;
        t_single(8'h11, 16'h1234);
        t_burst(5, 8'h20);
        t_idle();
        t_fx_only();
        skew_ns = 1.5;
        repeat (2) @(posedge clk_slow);
        t_single(8'h42, 16'hA5A5);
        t_burst(4, 8'h60);
        skew_ns = 3.0;
        repeat (2) @(posedge clk_slow);
        t_single(8'h7E, 16'h0F0F);
        t_burst(6, 8'h90);
        t_idle();
        t_reset_mid();
        summary();
    end

    initial begin
        #(TFAST * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule